// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel byte into an asynchronous serial character on a single output line. A character starts with a single low start bit. Then come 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop interval that lasts one, one and a half or two bit times. The line rests high between characters.

Bit timing comes from a 16-bit divisor. The divisor divides the system clock to make a 16x oversample tick, and one bit lasts 16 ticks. The host offers a byte with a valid/ready handshake. The framing controls are sampled at the moment the byte is accepted: word length, long stop, parity enable, even select and stick parity. A break input pulls the line low for as long as it is held. It does not change the timing of a character in progress.

Top module: `sertx_top`

## Requirements
- R1: After a synchronous active-low reset, `tx_out` is 1, `tx_idle` is 1 and `in_ready` is 1.
- R2: A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the cycle after that edge, `in_ready` and `tx_idle` are 0 until the character ends.
- R3: The start bit is 0. It begins in the cycle after acceptance and lasts exactly 16·D clock cycles, where D is the divisor in effect.
- R4: `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The data bits are `in_data[0]` upward, sent least significant bit first, and each lasts 16·D cycles.
- R5: With `cfg_par_en`=1, one parity bit of 16·D cycles follows the data. With `cfg_par_stick`=0, `cfg_par_even`=1 makes the number of ones in data plus parity even, and `cfg_par_even`=0 makes it odd. With `cfg_par_stick`=1, the parity bit is the inverse of `cfg_par_even`. With `cfg_par_en`=0, no parity bit is sent.
- R6: The stop interval is 1 and lasts 16·D cycles when `cfg_stop_long`=0. With `cfg_stop_long`=1 it lasts 24·D cycles for 5-bit words and 32·D cycles for 6, 7 and 8-bit words.
- R7: While `cfg_break` is 1, `tx_out` is 0. Break does not change when the character ends.
- R8: A `cfg_div` value of 0 acts as 65536, so bit timing keeps running and the start bit is still being sent 50000 cycles after acceptance.
- R9: Changes to the framing inputs after acceptance do not alter the character in progress.
- R10: `tx_idle` and `in_ready` return to 1 exactly 16·D·(1+W+P) + S·D cycles after the accepting edge. W is the number of data bits, P is the number of parity bits and S is the number of stop ticks. The line is then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter can accept a byte |
| cfg_wlen | input | 2 | Word length code (5 + code bits) |
| cfg_stop_long | input | 1 | Long stop interval select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | Even parity select |
| cfg_par_stick | input | 1 | Fixed parity value select |
| cfg_break | input | 1 | Forces the line low |
| cfg_div | input | 16 | Clock divisor for the 16x tick, 0 acts as 65536 |
| tx_out | output | 1 | Serial output line |
| tx_idle | output | 1 | No character in progress |

## Verification
The oversample counter restarts on the accepting edge. Because of that, every line change falls exactly on edge 16·D·k after acceptance, and the end of the character falls on the edge at the full frame length. The bench counts falling edges from the accepting edge. It samples each bit at its midpoint, 8·D cycles into the bit. It checks `tx_idle` on the cycle before the computed end and again on the end cycle itself, so an error of a single cycle in frame length shows up. Break is checked one time unit after it is driven, because it reaches the line through logic with no register in the path.

// File: rtl/sertx_pkg.sv
// Shared types for the serial character transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package sertx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Oversample ticks per ordinary bit time.
    localparam int OVS = 16;
endpackage

// File: rtl/sertx_tick.sv
// Oversample tick generator: emits a one-cycle tick every LIMIT clocks,
// where LIMIT is the divisor, or 2**DIV_W when the divisor is zero.
// Assumes: clr restarts the phase so that the first tick arrives LIMIT
// cycles after the clearing edge.
module sertx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Effective period: zero maps to the full range.
    always_comb begin
        limit = (div == '0) ? (CNT_W'(1) << DIV_W) : CNT_W'(div);
    end

    assign tick = (cnt >= limit - CNT_W'(1));

    // Free-running count, restarted by clr or by reaching the period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R8
    zero_div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0 && tick && !clr) |=> !tick);

    // R3
    clr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && limit > CNT_W'(1)) |=> !tick);
endmodule

// File: rtl/sertx_parity.sv
// Parity bit calculator for a word of 5 to DATA_W bits.
// Assumes: DATA_W >= 5 and len_code selects 5 + len_code bits.
module sertx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic              even,
    input  logic              stick,
    output logic              par_bit
);
    localparam int MIN_BITS = 5;

    logic [DATA_W-1:0] keep;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_keep
            // Bit gi takes part if it lies inside the selected word length.
            assign keep[gi] = data[gi] &
                (gi < MIN_BITS + int'(len_code));
        end
    endgenerate

    // Reduce the used bits and apply the even, odd or fixed rule.
    always_comb begin
        if (stick) begin
            par_bit = ~even;
        end else if (even) begin
            par_bit = ^keep;
        end else begin
            par_bit = ~(^keep);
        end
    end
endmodule

// File: rtl/sertx_frame.sv
// Character sequencer: holds a latched byte and framing and steps through
// the start, data, parity and stop phases on oversample ticks.
// Assumes: start is asserted only while busy is low, and the tick phase is
// restarted on the same edge.
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        last_idx,
    input  logic              par_en,
    input  logic              par_bit,
    input  logic [4:0]        stop_last,
    output logic              tx_q,
    output logic              busy
);
    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [2:0]        idx;
    logic [2:0]        last_idx_q;
    logic              par_en_q;
    logic              par_q;
    logic [4:0]        stop_last_q;
    logic [4:0]        sub;
    logic [4:0]        sub_last;

    assign busy = (state != ST_IDLE);

    // Last oversample index of the current phase.
    always_comb begin
        sub_last = (state == ST_STOP) ? stop_last_q : 5'(OVS - 1);
    end

    // Phase sequencing, shifting and line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tx_q        <= 1'b1;
            shreg       <= '0;
            idx         <= '0;
            sub         <= '0;
            last_idx_q  <= '0;
            par_en_q    <= 1'b0;
            par_q       <= 1'b0;
            stop_last_q <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                state       <= ST_START;
                tx_q        <= 1'b0;
                shreg       <= data;
                idx         <= '0;
                sub         <= '0;
                last_idx_q  <= last_idx;
                par_en_q    <= par_en;
                par_q       <= par_bit;
                stop_last_q <= stop_last;
            end
        end else if (tick) begin
            if (sub != sub_last) begin
                sub <= sub + 5'd1;
            end else begin
                sub <= '0;
                case (state)
                    ST_START: begin
                        state <= ST_DATA;
                        tx_q  <= shreg[0];
                        shreg <= shreg >> 1;
                        idx   <= '0;
                    end
                    ST_DATA: begin
                        if (idx == last_idx_q) begin
                            state <= par_en_q ? ST_PARITY : ST_STOP;
                            tx_q  <= par_en_q ? par_q : 1'b1;
                        end else begin
                            idx   <= idx + 3'd1;
                            tx_q  <= shreg[0];
                            shreg <= shreg >> 1;
                        end
                    end
                    ST_PARITY: begin
                        state <= ST_STOP;
                        tx_q  <= 1'b1;
                    end
                    default: begin
                        state <= ST_IDLE;
                        tx_q  <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> !tx_q);

    // R6
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> tx_q);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_q);

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (idx <= last_idx_q));

    // R6
    sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sub <= sub_last));
endmodule

// File: rtl/sertx_top.sv
// Top of the serial character transmitter: handshake, framing decode,
// tick generator, parity and sequencer.
// Assumes: framing inputs are only needed valid on the accepting edge.
module sertx_top #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_stop_long,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    input  logic              cfg_break,
    input  logic [DIV_W-1:0]  cfg_div,
    output logic              tx_out,
    output logic              tx_idle
);
    localparam int SHORT_STOP = 16;
    localparam int HALF_STOP  = 24;
    localparam int LONG_STOP  = 32;

    logic       tick;
    logic       busy;
    logic       accept;
    logic       par_bit;
    logic       tx_q;
    logic [2:0] last_idx;
    logic [4:0] stop_last;

    assign in_ready = ~busy;
    assign tx_idle  = ~busy;
    assign accept   = in_valid & ~busy;
    assign tx_out   = tx_q & ~cfg_break;

    // Decode word length and stop interval into sequencer limits.
    always_comb begin
        last_idx = 3'(4 + int'(cfg_wlen));
        if (!cfg_stop_long) begin
            stop_last = 5'(SHORT_STOP - 1);
        end else if (cfg_wlen == 2'd0) begin
            stop_last = 5'(HALF_STOP - 1);
        end else begin
            stop_last = 5'(LONG_STOP - 1);
        end
    end

    sertx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .div   (cfg_div),
        .tick  (tick)
    );

    sertx_parity #(.DATA_W(DATA_W)) u_par (
        .data     (in_data),
        .len_code (cfg_wlen),
        .even     (cfg_par_even),
        .stick    (cfg_par_stick),
        .par_bit  (par_bit)
    );

    sertx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (accept),
        .data      (in_data),
        .last_idx  (last_idx),
        .par_en    (cfg_par_en),
        .par_bit   (par_bit),
        .stop_last (stop_last),
        .tx_q      (tx_q),
        .busy      (busy)
    );

    // R7
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |-> !tx_out);

    // R2
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_break) |=> (!in_ready && !tx_out));
endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  in_data;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  cfg_wlen;
    logic        cfg_stop_long;
    logic        cfg_par_en;
    logic        cfg_par_even;
    logic        cfg_par_stick;
    logic        cfg_break;
    logic [15:0] cfg_div;
    logic        tx_out;
    logic        tx_idle;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sertx_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .cfg_wlen      (cfg_wlen),
        .cfg_stop_long (cfg_stop_long),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_even  (cfg_par_even),
        .cfg_par_stick (cfg_par_stick),
        .cfg_break     (cfg_break),
        .cfg_div       (cfg_div),
        .tx_out        (tx_out),
        .tx_idle       (tx_idle)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Sends one character and checks every bit midpoint, the stop level
    // and the exact end cycle. Break is held during [bk_from, bk_to).
    task automatic send_frame(input logic [7:0] d, input int wl, input bit sl,
                              input int pmode, input int dv,
                              input int bk_from, input int bk_to);
        bit pe, ev, st;
        bit exp_bits[12];
        int nbits, ones, stop_t, bt, total, mid_stop;
        pe = (pmode != 0);
        ev = (pmode == 2) || (pmode == 4);
        st = (pmode >= 3);
        while (!in_ready) @(negedge clk);
        in_data = d; cfg_wlen = 2'(wl); cfg_stop_long = sl;
        cfg_par_en = pe; cfg_par_even = ev; cfg_par_stick = st;
        cfg_div = 16'(dv); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        // R9: scramble framing and data after acceptance
        in_data = ~d; cfg_wlen = ~cfg_wlen; cfg_stop_long = ~sl;
        cfg_par_en = ~pe; cfg_par_even = ~ev; cfg_par_stick = ~st;
        // R2
        check(!in_ready && !tx_idle, "R2", int'(in_ready), 0);
        exp_bits[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < 5 + wl; i++) begin
            exp_bits[1 + i] = d[i];
            ones += int'(d[i]);
        end
        nbits = 1 + 5 + wl;
        if (pe) begin
            if (st)      exp_bits[nbits] = !ev;
            else if (ev) exp_bits[nbits] = (ones % 2) == 1;
            else         exp_bits[nbits] = (ones % 2) == 0;
            nbits++;
        end
        stop_t = !sl ? 16 : (wl == 0 ? 24 : 32);
        bt = 16 * dv;
        total = bt * nbits + stop_t * dv;
        mid_stop = bt * nbits + (stop_t * dv) / 2;
        for (int t = 1; t <= total; t++) begin
            bit brk;
            @(negedge clk);
            brk = (t >= bk_from) && (t < bk_to);
            cfg_break = brk;
            #1;
            if ((t % bt) == bt / 2 && (t / bt) < nbits) begin
                int k;
                k = t / bt;
                if (brk)
                    check(tx_out == 1'b0, "R7", int'(tx_out), 0);
                else if (k == 0)
                    check(tx_out == 1'b0, "R3", int'(tx_out), 0);
                else if (k <= 5 + wl)
                    check(tx_out == exp_bits[k], "R4", int'(tx_out), int'(exp_bits[k]));
                else
                    check(tx_out == exp_bits[k], "R5", int'(tx_out), int'(exp_bits[k]));
            end
            // R3: start still low on its last cycle, data begins right after
            if (t == bt - 1 && !brk)
                check(tx_out == 1'b0, "R3", int'(tx_out), 0);
            if (t == mid_stop && !brk)
                check(tx_out == 1'b1, "R6", int'(tx_out), 1);
            if (t == total - 1)
                check(!tx_idle, "R10", int'(tx_idle), 0);
            if (t == total) begin
                check(tx_idle && in_ready && tx_out, "R10",
                      int'({tx_idle, in_ready, tx_out}), 7);
            end
        end
        cfg_break = 1'b0;
    endtask

    initial begin
        int n = 0;
        while (n < WATCHDOG && !done) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            check(1'b0, "watchdog", n, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_data = '0; in_valid = 1'b0; cfg_wlen = '0;
        cfg_stop_long = 1'b0; cfg_par_en = 1'b0; cfg_par_even = 1'b0;
        cfg_par_stick = 1'b0; cfg_break = 1'b0; cfg_div = 16'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(tx_out && tx_idle && in_ready, "R1",
              int'({tx_out, tx_idle, in_ready}), 7);

        // Sweep: divisor, word length, stop select, parity mode, data
        for (int dv = 1; dv <= 2; dv++)
            for (int wl = 0; wl < 4; wl++)
                for (int sl = 0; sl < 2; sl++)
                    for (int pm = 0; pm < 5; pm++)
                        for (int dx = 0; dx < 2; dx++)
                            send_frame(8'(8'h5A ^ (wl * 37 + pm * 11 + dx * 133)),
                                       wl, sl[0], pm, dv, -1, -1);

        // R7: break while idle, then mid-frame without moving the end
        @(negedge clk);
        cfg_break = 1'b1; #1;
        check(tx_out == 1'b0, "R7", int'(tx_out), 0);
        @(negedge clk);
        cfg_break = 1'b0; #1;
        check(tx_out == 1'b1, "R7", int'(tx_out), 1);
        send_frame(8'hC3, 3, 1'b1, 1, 3, 40, 200);

        // R8: divisor zero keeps the start bit running for a long time
        while (!in_ready) @(negedge clk);
        in_data = 8'hFF; cfg_wlen = 2'd3; cfg_stop_long = 1'b0;
        cfg_par_en = 1'b0; cfg_div = 16'd0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (50000) @(negedge clk);
        check(tx_out == 1'b0 && !tx_idle, "R8",
              int'({tx_out, tx_idle}), 0);

        // R1: reset in the middle of a character
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_out && tx_idle && in_ready, "R1",
              int'({tx_out, tx_idle, in_ready}), 7);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule